// File: doc/BRIEF.md
# Debug Trigger Match and Chain Unit

This block holds a bank of hardware debug triggers for a processor core. Software configures it through a small register port. One register picks a trigger by index. The control word and compare value that follow then belong to that trigger. A global word carries the master enable. All configuration fields are write-any-read-legal: any value may be written, but only the options the hardware supports are stored, and unsupported bits read back as zero.

On every accepted event the unit evaluates all triggers in parallel. An event is an instruction execute, a load or a store, marked as a before-execution or after-completion check, and it carries an address and a data value. Neighbouring triggers can be linked into AND-chains of capped length, and the last trigger of a chain supplies the action. One cycle later the unit emits a single pulse. The pulse carries the winning action (halt into debug mode, exception or trace) and the index of the trigger that ends the firing chain.

Events arrive on a valid/ready input. Ready is held high permanently, so the unit never applies back-pressure, and an event is consumed in every cycle where its valid is high. The action output is a plain strobe with no handshake: the core must act on it in the cycle it is high.

Top module: `dbg_trig_unit`

## Requirements
- R1: Writing the select word (register address 0) stores the index. A value of N or more is stored as N-1. Reading address 0 returns the stored index.
- R2: The control word (register address 1) of the selected trigger uses these bits: bit0 execute, bit1 load, bit2 store, bit3 data-value compare, bit4 after-completion, bit5 chain, bits 9:8 action. Every other bit reads back 0. Bit3 reads back 0 when data compare is compiled out.
- R3: The compare word (register address 2) is stored per trigger. It reads back exactly as written for the selected trigger.
- R4: A trigger hits only if it is enabled for at least one of the event's kinds and its compare word equals the event address. When bit3 is set and data compare is present, the compare word must instead equal the event data.
- R5: A trigger with bit4 clear responds only to before-execution events (ev_after=0). A trigger with bit4 set responds only to after-completion events (ev_after=1).
- R6: A chain is a run of triggers in which each trigger except the last has bit5 set. It fires only if every member hits on the same event.
- R7: A chain-bit write that would make a chain longer than MAX_CHAIN triggers is dropped, and bit5 reads 0. The last trigger's chain bit always reads 0.
- R8: Action codes are 0 chained/none, 1 halt, 2 exception and 3 trace. A chain acts with the code of its last trigger. A code of 0 there produces no action.
- R9: An event accepted in a cycle yields act_valid high for exactly the following cycle, carrying act_code and act_idx (the last trigger of the chain). With no firing chain, act_valid is 0 and act_code and act_idx are 0.
- R10: When several chains fire together, halt beats exception and exception beats trace. Within one code, the lowest-indexed chain wins.
- R11: No action is requested while in_debug is high or while the global enable (register address 3, bit0) is 0.
- R12: ev_ready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address: 0 select, 1 control, 2 compare, 3 global |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data, combinational from csr_addr |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Always high |
| ev_exec | input | 1 | Event is an instruction execute |
| ev_load | input | 1 | Event is a load |
| ev_store | input | 1 | Event is a store |
| ev_after | input | 1 | Event is an after-completion check |
| ev_addr | input | XLEN | PC or data address |
| ev_data | input | XLEN | Data value |
| in_debug | input | 1 | Hart already in debug mode |
| act_valid | output | 1 | One-cycle action request |
| act_code | output | 2 | Action code |
| act_idx | output | SEL_W | Index of the last trigger of the winning chain |

## Verification
Register reads are combinational, so the bench samples csr_rdata one time unit after it sets csr_addr, away from any edge. A register write takes effect at the clock edge that samples csr_we. Any event evaluated in that same cycle still sees the old configuration. The action result lands on the first edge after the event is presented, so the bench drives each event at a falling edge, lets one rising edge pass and compares all three action outputs at the next falling edge against a model built from the requirements.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_HALT  = 2'd1,
    ACT_EXC   = 2'd2,
    ACT_TRACE = 2'd3
  } act_e;

  // bit positions inside the control word
  localparam int B_EXEC   = 0;
  localparam int B_LOAD   = 1;
  localparam int B_STORE  = 2;
  localparam int B_DATA   = 3;
  localparam int B_AFTER  = 4;
  localparam int B_CHAIN  = 5;
  localparam int B_ACT_LO = 8;
  localparam int CTRL_W   = 16;

  localparam logic [1:0] REG_SEL  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_CMP  = 2'd2;
  localparam logic [1:0] REG_GLOB = 2'd3;

  typedef struct packed {
    logic [1:0] act;
    logic       chain;
    logic       after;
    logic       data_mode;
    logic       on_store;
    logic       on_load;
    logic       on_exec;
  } trig_cfg_t;

  function automatic logic [CTRL_W-1:0] cfg_to_word(trig_cfg_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[B_EXEC]          = c.on_exec;
    w[B_LOAD]          = c.on_load;
    w[B_STORE]         = c.on_store;
    w[B_DATA]          = c.data_mode;
    w[B_AFTER]         = c.after;
    w[B_CHAIN]         = c.chain;
    w[B_ACT_LO +: 2]   = c.act;
    return w;
  endfunction

endpackage

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs
  import dbg_trig_pkg::*;
#(
  parameter int N_TRIG    = 4,
  parameter int XLEN      = 32,
  parameter int MAX_CHAIN = 2,
  parameter bit HAS_DATA  = 1'b1,
  localparam int SEL_W    = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         csr_we,
  input  logic [1:0]                   csr_addr,
  input  logic [XLEN-1:0]              csr_wdata,
  output logic [XLEN-1:0]              csr_rdata,
  output trig_cfg_t [N_TRIG-1:0]       cfg_o,
  output logic [N_TRIG-1:0][XLEN-1:0]  cmp_o,
  output logic                         glob_en_o
);

  logic [SEL_W-1:0]              sel_q;
  trig_cfg_t [N_TRIG-1:0]        cfg_q;
  logic [N_TRIG-1:0][XLEN-1:0]   cmp_q;
  logic                          glob_q;

  logic [SEL_W-1:0] sel_new;
  trig_cfg_t        cfg_new;
  int               left_run;
  int               right_run;
  logic             left_stop;
  logic             right_stop;
  logic             chain_ok;

  // clamp of the select index
  always_comb begin
    if (csr_wdata >= XLEN'(N_TRIG)) sel_new = SEL_W'(N_TRIG - 1);
    else                            sel_new = csr_wdata[SEL_W-1:0];
  end

  // length of the chain that a new chain bit on the selected trigger would form
  always_comb begin
    left_run   = 0;
    left_stop  = 1'b0;
    for (int j = N_TRIG - 1; j >= 0; j--) begin
      if (j < int'(sel_q) && !left_stop) begin
        if (cfg_q[j].chain) left_run = left_run + 1;
        else                left_stop = 1'b1;
      end
    end
    right_run  = 0;
    right_stop = 1'b0;
    for (int k = 0; k < N_TRIG; k++) begin
      if (k > int'(sel_q) && !right_stop) begin
        if (cfg_q[k].chain) right_run = right_run + 1;
        else                right_stop = 1'b1;
      end
    end
    chain_ok = (int'(sel_q) < N_TRIG - 1) && (left_run + right_run + 2 <= MAX_CHAIN);
  end

  // legal subset of a control write
  always_comb begin
    cfg_new           = '0;
    cfg_new.on_exec   = csr_wdata[B_EXEC];
    cfg_new.on_load   = csr_wdata[B_LOAD];
    cfg_new.on_store  = csr_wdata[B_STORE];
    cfg_new.data_mode = HAS_DATA ? csr_wdata[B_DATA] : 1'b0;
    cfg_new.after     = csr_wdata[B_AFTER];
    cfg_new.chain     = csr_wdata[B_CHAIN] && chain_ok;
    cfg_new.act       = csr_wdata[B_ACT_LO +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      glob_q <= 1'b0;
    end else if (csr_we) begin
      if (csr_addr == REG_SEL)  sel_q  <= sel_new;
      if (csr_addr == REG_GLOB) glob_q <= csr_wdata[0];
    end
  end

  for (genvar g = 0; g < N_TRIG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
        cmp_q[g] <= '0;
      end else if (csr_we && int'(sel_q) == g) begin
        if (csr_addr == REG_CTRL) cfg_q[g] <= cfg_new;
        if (csr_addr == REG_CMP)  cmp_q[g] <= csr_wdata;
      end
    end

    if (!HAS_DATA) begin : g_nodata
      assert_no_data_bit_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[g].data_mode);
    end
  end

  always_comb begin
    unique case (csr_addr)
      REG_SEL:  csr_rdata = XLEN'(sel_q);
      REG_CTRL: csr_rdata = XLEN'(cfg_to_word(cfg_q[sel_q]));
      REG_CMP:  csr_rdata = cmp_q[sel_q];
      default:  csr_rdata = XLEN'(glob_q);
    endcase
  end

  assign cfg_o     = cfg_q;
  assign cmp_o     = cmp_q;
  assign glob_en_o = glob_q;

  // longest stored chain, measured independently of the write-side legaliser
  int run_len;
  int max_len;
  always_comb begin
    run_len = 0;
    max_len = 1;
    for (int i = 0; i < N_TRIG; i++) begin
      if (cfg_q[i].chain) run_len = run_len + 1;
      else                run_len = 0;
      if (run_len + 1 > max_len) max_len = run_len + 1;
    end
  end

  assert_chain_cap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    max_len <= MAX_CHAIN);

  assert_tail_unchained_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[N_TRIG-1].chain);

  assert_sel_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) <= N_TRIG - 1);

endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
  import dbg_trig_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit HAS_DATA = 1'b1
) (
  input  trig_cfg_t        cfg,
  input  logic [XLEN-1:0]  cmp,
  input  logic             ev_exec,
  input  logic             ev_load,
  input  logic             ev_store,
  input  logic             ev_after,
  input  logic [XLEN-1:0]  ev_addr,
  input  logic [XLEN-1:0]  ev_data,
  output logic             hit
);

  logic            kind_ok;
  logic [XLEN-1:0] probe;

  assign kind_ok = (cfg.on_exec  && ev_exec) ||
                   (cfg.on_load  && ev_load) ||
                   (cfg.on_store && ev_store);

  if (HAS_DATA) begin : g_data
    assign probe = cfg.data_mode ? ev_data : ev_addr;
  end else begin : g_addr_only
    assign probe = ev_addr;
  end

  assign hit = kind_ok && (cfg.after == ev_after) && (probe == cmp);

  logic unused_fields;
  assign unused_fields = ^{cfg.chain, cfg.act, cfg.data_mode, ev_data};

endmodule

// File: rtl/dbg_trig_chain.sv
module dbg_trig_chain
  import dbg_trig_pkg::*;
#(
  parameter int N_TRIG = 4,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  trig_cfg_t [N_TRIG-1:0]  cfg,
  input  logic [N_TRIG-1:0]       hit,
  input  logic                    ev_valid,
  input  logic                    glob_en,
  input  logic                    in_debug,
  output logic                    act_valid,
  output logic [1:0]              act_code,
  output logic [SEL_W-1:0]        act_idx
);

  logic [N_TRIG-1:0] acc;
  logic [N_TRIG-1:0] end_fire;

  // running AND along each chain; a trigger whose left neighbour is unchained starts afresh
  for (genvar g = 0; g < N_TRIG; g++) begin : g_link
    if (g == 0) begin : g_head
      assign acc[g] = hit[g];
    end else begin : g_body
      assign acc[g] = hit[g] && (cfg[g-1].chain ? acc[g-1] : 1'b1);
    end
    assign end_fire[g] = !cfg[g].chain && acc[g] && (cfg[g].act != ACT_NONE);
  end

  // per action class, the lowest firing chain end
  logic [3:1]            cls_v;
  logic [3:1][SEL_W-1:0] cls_idx;
  always_comb begin
    for (int c = 1; c <= 3; c++) begin
      cls_v[c]   = 1'b0;
      cls_idx[c] = '0;
      for (int i = N_TRIG - 1; i >= 0; i--) begin
        if (end_fire[i] && cfg[i].act == 2'(c)) begin
          cls_v[c]   = 1'b1;
          cls_idx[c] = SEL_W'(i);
        end
      end
    end
  end

  logic             go;
  logic [1:0]       win_code;
  logic [SEL_W-1:0] win_idx;

  assign go = ev_valid && glob_en && !in_debug && (|cls_v);

  always_comb begin
    if (cls_v[1]) begin
      win_code = ACT_HALT;
      win_idx  = cls_idx[1];
    end else if (cls_v[2]) begin
      win_code = ACT_EXC;
      win_idx  = cls_idx[2];
    end else begin
      win_code = ACT_TRACE;
      win_idx  = cls_idx[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_code  <= '0;
      act_idx   <= '0;
    end else begin
      act_valid <= go;
      act_code  <= go ? win_code : 2'd0;
      act_idx   <= go ? win_idx  : '0;
    end
  end

  assert_needs_event_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(ev_valid));

  assert_gated_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(glob_en && !in_debug));

  assert_real_action_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> act_code != ACT_NONE);

  assert_quiet_idle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |-> (act_code == 2'd0 && act_idx == '0));

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int N_TRIG    = 4,
  parameter int XLEN      = 32,
  parameter int MAX_CHAIN = 2,
  parameter bit HAS_DATA  = 1'b1,
  localparam int SEL_W    = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_exec,
  input  logic              ev_load,
  input  logic              ev_store,
  input  logic              ev_after,
  input  logic [XLEN-1:0]   ev_addr,
  input  logic [XLEN-1:0]   ev_data,
  input  logic              in_debug,
  output logic              act_valid,
  output logic [1:0]        act_code,
  output logic [SEL_W-1:0]  act_idx
);

  trig_cfg_t [N_TRIG-1:0]       cfg;
  logic [N_TRIG-1:0][XLEN-1:0]  cmp;
  logic                         glob_en;
  logic [N_TRIG-1:0]            hit;

  assign ev_ready = 1'b1;

  dbg_trig_regs #(
    .N_TRIG(N_TRIG), .XLEN(XLEN), .MAX_CHAIN(MAX_CHAIN), .HAS_DATA(HAS_DATA)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cfg_o(cfg), .cmp_o(cmp), .glob_en_o(glob_en)
  );

  for (genvar g = 0; g < N_TRIG; g++) begin : g_cmp
    dbg_trig_match #(.XLEN(XLEN), .HAS_DATA(HAS_DATA)) u_match (
      .cfg(cfg[g]), .cmp(cmp[g]),
      .ev_exec(ev_exec), .ev_load(ev_load), .ev_store(ev_store), .ev_after(ev_after),
      .ev_addr(ev_addr), .ev_data(ev_data),
      .hit(hit[g])
    );
  end

  dbg_trig_chain #(.N_TRIG(N_TRIG)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .cfg(cfg), .hit(hit),
    .ev_valid(ev_valid), .glob_en(glob_en), .in_debug(in_debug),
    .act_valid(act_valid), .act_code(act_code), .act_idx(act_idx)
  );

  assert_ready_R12 : assert property (@(posedge clk) disable iff (!rst_n) ev_ready);

endmodule

// File: tb/test_dbg_trig_unit.sv
module test_dbg_trig_unit;
  localparam int N    = 4;
  localparam int XLEN = 32;
  localparam int MAXC = 2;
  localparam bit HASD = 1'b1;
  localparam int SW   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic ev_valid = 1'b0, ev_ready;
  logic ev_exec = 1'b0, ev_load = 1'b0, ev_store = 1'b0, ev_after = 1'b0;
  logic [XLEN-1:0] ev_addr = '0, ev_data = '0;
  logic in_debug = 1'b0;
  logic act_valid;
  logic [1:0] act_code;
  logic [SW-1:0] act_idx;

  always #2 clk = ~clk;

  dbg_trig_unit #(.N_TRIG(N), .XLEN(XLEN), .MAX_CHAIN(MAXC), .HAS_DATA(HASD)) i_dbg_trig_unit (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_exec(ev_exec),
    .ev_load(ev_load), .ev_store(ev_store), .ev_after(ev_after), .ev_addr(ev_addr),
    .ev_data(ev_data), .in_debug(in_debug), .act_valid(act_valid), .act_code(act_code),
    .act_idx(act_idx)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_ctrl [N];
  logic [31:0] m_cmp  [N];
  bit m_glob = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] legal(int i, logic [31:0] w);
    logic [31:0] v;
    int l, r;
    v = w & (32'h317 | (HASD ? 32'h8 : 32'h0));
    if (w[5] && i < N - 1) begin
      l = 0;
      for (int j = i - 1; j >= 0 && m_ctrl[j][5]; j--) l++;
      r = 0;
      for (int k = i + 1; k < N && m_ctrl[k][5]; k++) r++;
      if (l + r + 2 <= MAXC) v[5] = 1'b1;
    end
    return v;
  endfunction

  task automatic csr_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(logic [1:0] a, logic [31:0] exp, string req);
    csr_addr = a;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic cfg_trig(int i, logic [31:0] ctrl, logic [31:0] cv);
    csr_wr(2'd0, i);
    csr_wr(2'd1, ctrl);
    m_ctrl[i] = legal(i, ctrl);
    csr_wr(2'd2, cv);
    m_cmp[i] = cv;
    csr_rd(2'd1, m_ctrl[i], "R2 R7 control readback");
    csr_rd(2'd2, m_cmp[i], "R3 compare readback");
  endtask

  task automatic set_glob(bit e);
    csr_wr(2'd3, {31'b0, e});
    m_glob = e;
    csr_rd(2'd3, {31'b0, e}, "R11 global enable readback");
  endtask

  task automatic model(bit ex, bit ld, bit st, bit af, logic [31:0] a, logic [31:0] d,
                       bit v, bit dbg, output bit ov, output int oc, output int oi);
    bit hit [N];
    bit fire [N];
    bit acc;
    logic [31:0] c, val;
    acc = 1'b0;
    for (int i = 0; i < N; i++) begin
      c = m_ctrl[i];
      val = (HASD && c[3]) ? d : a;
      hit[i] = ((c[0] && ex) || (c[1] && ld) || (c[2] && st)) && (c[4] == af) && (val == m_cmp[i]);
      if (i > 0 && m_ctrl[i-1][5]) acc = acc && hit[i];
      else acc = hit[i];
      fire[i] = !c[5] && acc && (c[9:8] != 2'd0);
    end
    ov = 1'b0; oc = 0; oi = 0;
    for (int code = 1; code <= 3; code++)
      for (int i = 0; i < N; i++)
        if (!ov && fire[i] && int'(m_ctrl[i][9:8]) == code) begin
          ov = 1'b1; oc = code; oi = i;
        end
    if (!(v && m_glob && !dbg)) begin
      ov = 1'b0; oc = 0; oi = 0;
    end
  endtask

  task automatic do_ev(bit ex, bit ld, bit st, bit af, logic [31:0] a, logic [31:0] d,
                       bit v, bit dbg, string req);
    bit ev;
    int ec, ei;
    model(ex, ld, st, af, a, d, v, dbg, ev, ec, ei);
    @(negedge clk);
    ev_valid = v; ev_exec = ex; ev_load = ld; ev_store = st; ev_after = af;
    ev_addr = a; ev_data = d; in_debug = dbg;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; in_debug = 1'b0;
    chk({req, " R9 act_valid"}, {31'b0, act_valid}, {31'b0, ev});
    chk({req, " R8 act_code"}, {30'b0, act_code}, ec);
    chk({req, " R10 act_idx"}, {30'b0, act_idx}, ei);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_ctrl[i] = '0; m_cmp[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R9 reset act_valid", {31'b0, act_valid}, 32'd0);
    chk("R12 ready", {31'b0, ev_ready}, 32'd1);
    csr_rd(2'd0, 32'd0, "R1 reset select");
    csr_rd(2'd1, 32'd0, "R2 reset control");
    set_glob(1'b1);
    // R1 select clamp
    csr_wr(2'd0, 32'd9);
    csr_rd(2'd0, 32'd3, "R1 clamp high index");
    csr_wr(2'd0, 32'd2);
    csr_rd(2'd0, 32'd2, "R1 legal index");
    // R2 unsupported bits, R7 chain cap
    cfg_trig(0, 32'hFFFF_FFFF, 32'h0);
    chk("R2 all-ones control", m_ctrl[0], 32'h33F);
    cfg_trig(1, 32'hFFFF_FFFF, 32'h0);
    chk("R7 over-long chain dropped", m_ctrl[1], 32'h31F);
    cfg_trig(3, 32'h0000_0020, 32'h0);
    chk("R7 last trigger chain", m_ctrl[3], 32'h0);
    // R6 chain AND
    cfg_trig(0, 32'h021, 32'h1000);
    cfg_trig(1, 32'h109, 32'h55);
    do_ev(1, 0, 0, 0, 32'h1000, 32'h55, 1, 0, "R6 chain all hit");
    do_ev(1, 0, 0, 0, 32'h1000, 32'h54, 1, 0, "R6 chain partial");
    do_ev(1, 0, 0, 0, 32'h1004, 32'h55, 1, 0, "R6 chain head miss");
    // R5 timing
    cfg_trig(2, 32'h311, 32'h2000);
    do_ev(1, 0, 0, 0, 32'h2000, 32'h77, 1, 0, "R5 before event");
    do_ev(1, 0, 0, 1, 32'h2000, 32'h77, 1, 0, "R5 after event");
    // R10 priority
    cfg_trig(3, 32'h211, 32'h2000);
    do_ev(1, 0, 0, 1, 32'h2000, 32'h77, 1, 0, "R10 exception over trace");
    cfg_trig(3, 32'h311, 32'h2000);
    do_ev(1, 0, 0, 1, 32'h2000, 32'h77, 1, 0, "R10 lowest index");
    // R4 kinds
    cfg_trig(2, 32'h312, 32'h2000);
    do_ev(1, 0, 0, 1, 32'h2000, 32'h77, 1, 0, "R4 exec only");
    do_ev(0, 1, 0, 1, 32'h2000, 32'h77, 1, 0, "R4 load");
    do_ev(0, 0, 1, 1, 32'h2000, 32'h77, 1, 0, "R4 store none");
    // R11 suppression, R9 no event
    do_ev(0, 1, 0, 1, 32'h2000, 32'h77, 1, 1, "R11 in debug");
    do_ev(0, 1, 0, 1, 32'h2000, 32'h77, 0, 0, "R9 no valid");
    set_glob(1'b0);
    do_ev(0, 1, 0, 1, 32'h2000, 32'h77, 1, 0, "R11 global off");
    set_glob(1'b1);
    // R8 action 0 at chain end
    cfg_trig(3, 32'h011, 32'h2000);
    do_ev(1, 0, 0, 1, 32'h2000, 32'h77, 1, 0, "R8 chained code at end");
    // random mix
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) begin
        logic [31:0] w;
        w = $urandom;
        if ($urandom_range(0, 1) == 0) w = w & 32'h33F;
        cfg_trig($urandom_range(0, N - 1), w, 32'h100 * $urandom_range(0, 3));
      end else if (r < 17) begin
        set_glob($urandom_range(0, 3) != 0);
      end else begin
        do_ev($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), 32'h100 * $urandom_range(0, 3),
              32'h100 * $urandom_range(0, 3), $urandom_range(0, 15) != 0,
              $urandom_range(0, 15) == 0, "R6 random");
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule